// File: doc/BRIEF.md
# Streaming Single-Lane Traffic Update Engine

This block advances one single-lane road by one simulation time step. After a start pulse it reads the lane's cells in ascending order from a read memory, one cell per clock. It computes each car's new speed from the gap in front of it and a pseudo-random slowdown. It then writes the whole updated lane, in the same ascending order, to a separate write memory. Each cell is one byte that says whether a car is present, the car's speed (0 to 5 cells per step) and an overlap tag that marks cells shared with software.

A six-cell window holds the car being updated and the five cells in front of it. The updated car goes into a five-deep shift register together with its displacement. An output cell takes the one car whose displacement equals its distance behind that cell. Cars in cells tagged as the pass-through overlap region are written back unchanged. All other cars are updated and moved. A car that would move past the last cell leaves the lane.

Top module: `traffic_lane_engine`

## Requirements
- R1: After reset, rd_en, wr_en and done are low.
- R2: A start pulse from idle reads addresses 0 to NCELL-1, one per cycle. The read data for an address arrives one cycle after rd_en. The block then writes exactly NCELL cells, with consecutive ascending addresses from 0 to NCELL-1.
- R3: Cell byte layout: bit 0 means occupied, bits 3:1 hold the speed, bits 5:4 hold the tag, bits 7:6 are spare. For an updated car the new speed is min(speed+1, 5), limited to the number of consecutive empty cells directly ahead (at most 5). All cars use the speeds from before the step. Cells past the lane end count as empty.
- R4: After the limit of R3, the speed drops by one (never below 0) when the low byte of a 16-bit LFSR is below slow_thresh. The LFSR steps once per updated car: shift right, and XOR 0xB400 when the bit shifted out is 1. seed_load loads seed, and a zero seed loads 0x0001.
- R5: An updated car at cell k with new speed v is written to cell k+v. A car with k+v at or beyond NCELL is written nowhere.
- R6: A car in a cell with tag 01 (pass-through region) is written to its own cell with its speed unchanged, and it does not step the LFSR.
- R7: Cars with tag 10 (update region), 00 or 11 follow R3 to R5.
- R8: Written cell k keeps bits 7:4 of input cell k. Its bits 3:0 hold the car that lands there, or zero if no car lands there.
- R9: done pulses for one cycle, in the cycle after the write to address NCELL-1. A start pulse during a pass is ignored.
- R10: No written car has a speed above 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin one pass over the lane |
| seed_load | input | 1 | Load the LFSR from seed |
| seed | input | 16 | LFSR seed value |
| slow_thresh | input | 8 | Slowdown threshold |
| rd_en | output | 1 | Read strobe to the read memory |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Read data, one cycle after rd_en |
| wr_en | output | 1 | Write strobe to the write memory |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Updated cell |
| done | output | 1 | Pass complete |

## Verification
The landing and speed assertions assume that the input lane is a consistent traffic state. Every stored speed must be at most 5, and no two cars may reach the same cell. This holds whenever speeds are limited by the gap ahead. Every bench lane holds only legal speeds, so the one-landing assertion never sees two cars aimed at one cell. The bench loads the seed and starts a pass only while the block is idle. It checks the pass-through, spare-bit and lane-end cases against lane images worked out by hand.

// File: rtl/traffic_lane_engine.sv
module traffic_lane_engine #(
  parameter int NCELL = 64,
  parameter int AW    = $clog2(NCELL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          seed_load,
  input  logic [15:0]   seed,
  input  logic [7:0]    slow_thresh,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done
);
  localparam int LOOK = 5;
  localparam int CW   = $clog2(NCELL + LOOK + 2) + 1;
  localparam logic [CW-1:0] T_FIRST = CW'(LOOK + 2);
  localparam logic [CW-1:0] T_LAST  = CW'(NCELL + LOOK + 1);

  logic          busy;
  logic [CW-1:0] t;
  logic [7:0]    win [0:LOOK];
  logic [6:0]    park [0:LOOK-1];   // {valid, disp[2:0], speed[2:0]}
  logic [15:0]   lfsr;

  logic       proc, in_ok, occ, pass, slow, upd;
  logic [2:0] spd, gap, vacc, vlim, vnew, land_spd;
  logic [6:0] entry0;
  logic [LOOK:0] hits;
  logic [7:0] incoming;

  assign rd_en    = busy && (t < CW'(NCELL));
  assign rd_addr  = t[AW-1:0];
  assign in_ok    = busy && (t != '0) && (t <= CW'(NCELL));
  assign incoming = in_ok ? rd_data : 8'h00;
  assign proc     = busy && (t >= T_FIRST);

  assign occ  = win[0][0];
  assign spd  = win[0][3:1];
  assign pass = (win[0][5:4] == 2'b01);

  always_comb begin
    gap = 3'(LOOK);
    for (int i = LOOK; i >= 1; i--)
      if (win[i][0]) gap = 3'(i - 1);
  end

  assign vacc   = (spd >= 3'd5) ? 3'd5 : spd + 3'd1;
  assign vlim   = (vacc > gap) ? gap : vacc;
  assign slow   = (lfsr[7:0] < slow_thresh);
  assign vnew   = (slow && vlim != 3'd0) ? vlim - 3'd1 : vlim;
  assign upd    = proc && occ && !pass;
  assign entry0 = !occ ? 7'd0 : pass ? {1'b1, 3'd0, spd} : {1'b1, vnew, vnew};

  always_comb begin
    hits[0]  = entry0[6] && (entry0[5:3] == 3'd0);
    land_spd = hits[0] ? entry0[2:0] : 3'd0;
    for (int d = 1; d <= LOOK; d++) begin
      hits[d] = park[d-1][6] && (park[d-1][5:3] == 3'(d));
      if (hits[d]) land_spd = land_spd | park[d-1][2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      t    <= '0;
      for (int i = 0; i <= LOOK; i++) win[i] <= 8'h00;
      for (int i = 0; i < LOOK; i++)  park[i] <= 7'd0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= 8'h00;
      done    <= 1'b0;
    end else begin
      done  <= wr_en && (wr_addr == AW'(NCELL - 1));
      wr_en <= proc;
      if (proc) begin
        wr_addr <= AW'(t - T_FIRST);
        wr_data <= {win[0][7:4], land_spd, |hits};
        park[0] <= entry0;
        for (int i = 1; i < LOOK; i++) park[i] <= park[i-1];
      end
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          t    <= '0;
          for (int i = 0; i <= LOOK; i++) win[i] <= 8'h00;
          for (int i = 0; i < LOOK; i++)  park[i] <= 7'd0;
        end
      end else begin
        t <= t + 1'b1;
        if (t != '0) begin
          win[LOOK] <= incoming;
          for (int i = 0; i < LOOK; i++) win[i] <= win[i+1];
        end
        if (t == T_LAST) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lfsr <= 16'h0001;
    else if (seed_load)  lfsr <= (seed == 16'h0000) ? 16'h0001 : seed;
    else if (upd)        lfsr <= (lfsr >> 1) ^ (lfsr[0] ? 16'hB400 : 16'h0000);
  end

  AST_SPEED_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[0] |-> wr_data[3:1] <= 3'd5);                       // R10
  AST_ONE_LANDING: assert property (@(posedge clk) disable iff (!rst_n)
    proc |-> $onehot0(hits));                                             // R5
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) |-> wr_addr == AW'($past(wr_addr) + 1'b1));     // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en) && $past(wr_addr) == AW'(NCELL - 1));           // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                      // R9
endmodule

// File: tb/tb_traffic_lane_engine.sv
module tb_traffic_lane_engine;
  localparam int N  = 16;
  localparam int AW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, seed_load = 1'b0;
  logic [15:0] seed = 16'h0;
  logic [7:0]  slow_thresh = 8'h0;
  logic rd_en, wr_en, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;

  always #4 clk = ~clk;

  traffic_lane_engine #(.NCELL(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_load(seed_load), .seed(seed),
    .slow_thresh(slow_thresh), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  logic [7:0] rmem [N];
  logic [7:0] wmem [N];
  logic [7:0] rd_q;
  always @(posedge clk) if (rd_en) rd_q <= rmem[rd_addr];
  assign rd_data = rd_q;

  int tests = 0, fails = 0;
  int wcount, rcount, order_bad, done_cnt, done_bad, next_addr;
  logic prev_wr;
  logic [AW-1:0] prev_addr;

  always @(negedge clk) begin
    if (rd_en) rcount++;
    if (wr_en) begin
      if (wr_addr != AW'(next_addr)) order_bad++;
      wmem[wr_addr] = wr_data;
      wcount++;
      next_addr++;
    end
    if (done) begin
      done_cnt++;
      if (!(prev_wr && prev_addr == AW'(N - 1))) done_bad++;
    end
    prev_wr   = wr_en;
    prev_addr = wr_addr;
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] lane_out();
    logic [127:0] r;
    for (int i = 0; i < N; i++) r[8*i +: 8] = wmem[i];
    return r;
  endfunction

  task automatic load_seed(input logic [15:0] s);
    @(negedge clk); seed = s; seed_load = 1'b1;
    @(negedge clk); seed_load = 1'b0;
  endtask

  task automatic run_lane(input logic [127:0] lane, input bit extra_start);
    for (int i = 0; i < N; i++) begin
      rmem[i] = lane[8*i +: 8];
      wmem[i] = 8'hEE;
    end
    wcount = 0; rcount = 0; order_bad = 0; done_cnt = 0; done_bad = 0; next_addr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int c = 0; c < 200 && done_cnt == 0; c++) begin
      if (extra_start && c == 8) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (done_cnt == 0) begin
      tests++; fails++;
      $display("FAIL R9 actual=no done expected=done within 200 cycles");
    end
    repeat (30) @(negedge clk);
  endtask

  localparam int NV = 3;
  localparam logic [127:0] VEC_IN [NV] = '{
    128'h000B_0000_0009_0000_0000_0000_0500_0001,
    128'h0000_0000_0000_4500_C000_2023_0019_0007,
    128'h0000_0000_0000_0000_0000_0001_0B0B_0B0B};
  localparam logic [127:0] VEC_EXP [NV] = '{
    128'h0000_0700_0000_0000_0007_0000_0000_0300,
    128'h0000_0007_0000_4000_C005_2020_0019_0300,
    128'h0000_0000_0000_0000_0000_0300_0101_0101};
  localparam string VEC_REQ [NV] = '{"R3 R5", "R6 R7 R8", "R3"};

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {125'd0, rd_en, wr_en, done}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    slow_thresh = 8'd0;
    for (int v = 0; v < NV; v++) begin
      run_lane(VEC_IN[v], 1'b0);
      check(VEC_REQ[v], lane_out(), VEC_EXP[v]);
    end
    check("R2 write count", 128'(wcount), 128'(N));
    check("R2 read count", 128'(rcount), 128'(N));
    check("R2 write order", 128'(order_bad), 128'd0);
    check("R9 done timing", {96'd0, 32'(done_cnt), 32'(done_bad)}, {96'd0, 32'd1, 32'd0});

    // R4: seed 0x00FF, low byte 0xFF not below 255: no slowdown, speed 3
    slow_thresh = 8'd255;
    load_seed(16'h00FF);
    run_lane(128'h5, 1'b0);
    check("R4 no slow", lane_out(), 128'h0700_0000);
    // R4: LFSR stepped once to 0xB47F, low byte 0x7F below 255: speed 2
    run_lane(128'h5, 1'b0);
    check("R4 slow", lane_out(), 128'h0005_0000);

    // R4: zero seed loads 0x0001; threshold 2 slows, threshold 1 does not
    slow_thresh = 8'd2;
    load_seed(16'h0000);
    run_lane(128'h5, 1'b0);
    check("R4 zero seed slow", lane_out(), 128'h0005_0000);
    slow_thresh = 8'd1;
    load_seed(16'h0000);
    run_lane(128'h5, 1'b0);
    check("R4 zero seed no slow", lane_out(), 128'h0700_0000);

    // R4: speed 0 after limit stays 0 when slowed; second car slowed to 0 too
    slow_thresh = 8'd255;
    load_seed(16'h0001);
    run_lane(128'h0101, 1'b0);
    check("R4 floor at zero", lane_out(), 128'h0101);

    // R6: pass-through car untouched even with slowdown always armed
    run_lane(128'h1B00_0000, 1'b0);
    check("R6 pass-through", lane_out(), 128'h1B00_0000);

    // R5: car at last cell leaves lane
    slow_thresh = 8'd0;
    run_lane({8'h0B, 120'd0}, 1'b0);
    check("R5 drop at end", lane_out(), 128'd0);

    // R9: start during a pass is ignored
    run_lane(VEC_IN[0], 1'b1);
    check("R9 start ignored writes", 128'(wcount), 128'(N));
    check("R9 start ignored done", {96'd0, 32'(done_cnt), 32'(done_bad)}, {96'd0, 32'd1, 32'd0});
    check("R9 start ignored data", lane_out(), VEC_EXP[0]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule